// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block turns a reference frequency and a requested output frequency, both in Hz, into a PLL setting. The setting has four parts: a pre-divider P, a feedback multiplier M, a post-divide shift S and a 16-bit fractional word K. A caller loads both frequencies with a one-cycle `start` pulse. The engine then tests one candidate per clock. It answers with a one-cycle `done` pulse that carries either the first valid setting or a failure flag.

Before any search, the engine rejects requests that make no sense and requests whose output lies outside the supported band. If both frequencies are whole multiples of 1 MHz, it looks for an exact integer setting. Otherwise it looks for the M whose two neighbouring integer products bracket the VCO frequency. It then works out the fraction K with a shared restoring divider. That divider runs twice: once for the reference after the pre-divider, and once for K.

Top module: `pll_coef_search`

## Requirements
- R1: When the captured reference is 0, the captured output is 0, or the two are equal, the engine reports `fail` with `done`.
- R2: An output request below 37 000 000 Hz or above 4 500 000 000 Hz (both limits themselves allowed) ends with `fail`.
- R3: S is tried from 0 up to 6. The VCO candidate is the output shifted left by S, and any S whose VCO lies outside 2 250 000 000 to 4 500 000 000 Hz inclusive is skipped. A returned S always yields a VCO inside that window.
- R4: Integer mode applies when both frequencies are exact multiples of 1 000 000 Hz. P is tried over 2..4. A candidate is accepted only when floor(M·Fin/P) equals the VCO exactly, and K is then 0.
- R5: Fractional mode applies in every other case. P is tried over 1..4. A candidate is accepted when floor(M·Fin/P) ≤ VCO < floor((M+1)·Fin/P).
- R6: In fractional mode, with fref = floor(Fin/P), the returned K is the low 16 bits of floor((VCO − M·fref)·65536 / fref).
- R7: M is tried over 64..1023. The nesting is S outermost, then P, then M innermost, all ascending, and the first accepted candidate is the one returned.
- R8: If every candidate is rejected, `done` comes with `fail` high.
- R9: `busy` is high from the cycle after an accepted `start` through the cycle of `done`. `done` lasts one cycle. The result outputs hold their values until the next accepted `start`.
- R10: A `start` seen while `busy` is high, including the cycle in which `done` is high, is ignored. It changes neither the running search nor the reported result.
- R11: During and right after reset, `busy`, `done` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; accepted only while idle |
| ref_hz | input | FW | Reference frequency in Hz |
| out_hz | input | FW | Requested output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No setting found (valid with `done`) |
| pre_div | output | 3 | Pre-divider P |
| fb_mul | output | 10 | Feedback multiplier M |
| post_shift | output | 3 | Post-divide shift S |
| frac | output | 16 | Fractional word K |

## Verification
A new request and the completion pulse can fall in the same cycle, because `done` is the last cycle in which the engine is busy. The bench drives `start` with different frequencies in exactly the cycle where it sees `done` high. It also pulses `start` partway through a search. In both cases it judges the outcome by `busy` staying low afterwards and by the reported setting still matching the first request, as its arithmetic model predicts.

// File: rtl/pll_coef_search.sv
module pll_coef_search #(
  parameter int FW = 33,
  parameter int KW = 16,
  parameter longint unsigned UNIT_HZ = 64'd1_000_000,
  parameter longint unsigned OUT_MIN = 64'd37_000_000,
  parameter longint unsigned OUT_MAX = 64'd4_500_000_000,
  parameter longint unsigned VCO_MIN = 64'd2_250_000_000,
  parameter longint unsigned VCO_MAX = 64'd4_500_000_000,
  parameter int S_LAST = 6,
  parameter int P_LAST = 4,
  parameter int M_FIRST = 64,
  parameter int M_LAST = 1023,
  localparam int SW = $clog2(S_LAST + 1),
  localparam int PW = $clog2(P_LAST + 1),
  localparam int MW = $clog2(M_LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] ref_hz,
  input  logic [FW-1:0] out_hz,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [PW-1:0] pre_div,
  output logic [MW-1:0] fb_mul,
  output logic [SW-1:0] post_shift,
  output logic [KW-1:0] frac
);
  localparam int XW = FW + KW + 2;
  localparam int CW = $clog2(XW + 1);

  typedef enum logic [2:0] {IDLE, CHK, SRCH, DIVF, DIVK, FIN} st_t;
  st_t st;

  logic [XW-1:0] fin_q, fout_q, vco;
  logic          intm, fail_q;
  logic [SW-1:0] s_c;
  logic [PW-1:0] p_c;
  logic [MW-1:0] m_c;
  logic [KW-1:0] k_q;
  logic [XW-1:0] rem, quo, dvsr;
  logic [CW-1:0] cnt;

  wire [XW-1:0] ref_x  = XW'(ref_hz);
  wire [XW-1:0] out_x  = XW'(out_hz);
  wire [XW-1:0] prod   = XW'(m_c) * fin_q;
  wire [XW-1:0] vp     = vco * XW'(p_c);
  wire [XW-1:0] hi     = vp + XW'(p_c);
  wire          vco_ok = (vco >= XW'(VCO_MIN)) && (vco <= XW'(VCO_MAX));
  wire          hit    = intm ? (prod >= vp && prod < hi) : (prod < hi && hi <= prod + fin_q);
  wire          bad    = (fin_q == '0) || (fout_q == '0) || (fin_q == fout_q) ||
                         (fout_q < XW'(OUT_MIN)) || (fout_q > XW'(OUT_MAX));
  wire [PW-1:0] p_first = intm ? PW'(2) : PW'(1);
  wire [XW-1:0] rsh    = {rem[XW-2:0], quo[XW-1]};
  wire          rge    = rsh >= dvsr;
  wire          last_c = (m_c == MW'(M_LAST)) && (p_c == PW'(P_LAST));

  assign busy       = (st != IDLE);
  assign done       = (st == FIN);
  assign fail       = fail_q;
  assign pre_div    = p_c;
  assign fb_mul     = m_c;
  assign post_shift = s_c;
  assign frac       = k_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      fin_q <= '0; fout_q <= '0; vco <= '0;
      intm <= 1'b0; fail_q <= 1'b0;
      s_c <= '0; p_c <= '0; m_c <= '0; k_q <= '0;
      rem <= '0; quo <= '0; dvsr <= '0; cnt <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          fin_q  <= ref_x;
          fout_q <= out_x;
          intm   <= ((ref_x % XW'(UNIT_HZ)) == '0) && ((out_x % XW'(UNIT_HZ)) == '0);
          st     <= CHK;
        end
        CHK: begin
          s_c <= '0; p_c <= p_first; m_c <= MW'(M_FIRST);
          vco <= fout_q; k_q <= '0; fail_q <= bad;
          st  <= bad ? FIN : SRCH;
        end
        SRCH: begin
          if (vco_ok && hit) begin
            if (intm) st <= FIN;
            else begin
              rem <= '0; quo <= fin_q; dvsr <= XW'(p_c); cnt <= CW'(XW);
              st  <= DIVF;
            end
          end else if (!vco_ok || last_c) begin
            if (s_c == SW'(S_LAST)) begin
              fail_q <= 1'b1;
              st     <= FIN;
            end else begin
              s_c <= s_c + 1'b1; vco <= vco << 1;
              p_c <= p_first; m_c <= MW'(M_FIRST);
            end
          end else if (m_c == MW'(M_LAST)) begin
            m_c <= MW'(M_FIRST);
            p_c <= p_c + 1'b1;
          end else begin
            m_c <= m_c + 1'b1;
          end
        end
        DIVF, DIVK: begin
          if (cnt != '0) begin
            rem <= rge ? rsh - dvsr : rsh;
            quo <= {quo[XW-2:0], rge};
            cnt <= cnt - 1'b1;
          end else if (st == DIVF) begin
            rem  <= '0;
            quo  <= (vco - XW'(m_c) * quo) << KW;
            dvsr <= quo;
            cnt  <= CW'(XW);
            st   <= DIVK;
          end else begin
            k_q <= quo[KW-1:0];
            st  <= FIN;
          end
        end
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire [XW-1:0] vco_res = fout_q << post_shift;
  wire [XW-1:0] pr_res  = XW'(fb_mul) * fin_q;
  wire [XW-1:0] vp_res  = vco_res * XW'(pre_div);

  a_r1_trivial_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (fin_q != '0 && fout_q != '0 && fin_q != fout_q));
  a_r2_output_band: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (fout_q >= XW'(OUT_MIN) && fout_q <= XW'(OUT_MAX)));
  a_r3_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (post_shift <= SW'(S_LAST) && vco_res >= XW'(VCO_MIN) && vco_res <= XW'(VCO_MAX)));
  a_r4_integer_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && intm) |-> (frac == '0 && pre_div >= PW'(2) && pre_div <= PW'(P_LAST) &&
                                 pr_res >= vp_res && pr_res < vp_res + XW'(pre_div)));
  a_r5_frac_bracket: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail && !intm) |-> (pre_div >= PW'(1) && pre_div <= PW'(P_LAST) &&
                                  pr_res < vp_res + XW'(pre_div) && vp_res + XW'(pre_div) <= pr_res + fin_q));
  a_r7_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (fb_mul >= MW'(M_FIRST) && fb_mul <= MW'(M_LAST)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(fail) && $stable(pre_div) && $stable(fb_mul) && $stable(post_shift) && $stable(frac)));
  a_r10_inputs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(fin_q) && $stable(fout_q)));
endmodule

// File: tb/pll_coef_search_bench.sv
module pll_coef_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 33;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] ref_hz = '0, out_hz = '0;
  logic busy, done, fail;
  logic [2:0] pre_div, post_shift;
  logic [9:0] fb_mul;
  logic [15:0] frac;
  int checks = 0, errs = 0;

  pll_coef_search u_pll_coef_search (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .out_hz(out_hz),
    .busy(busy), .done(done), .fail(fail), .pre_div(pre_div), .fb_mul(fb_mul),
    .post_shift(post_shift), .frac(frac));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint unsigned fi, input longint unsigned fo,
                                output bit ok, output longint unsigned ep, output longint unsigned em,
                                output longint unsigned es, output longint unsigned ek);
    bit integ;
    longint unsigned vco, fref;
    ok = 0; ep = 0; em = 0; es = 0; ek = 0;
    if (fi == 0 || fo == 0 || fi == fo) return;
    if (fo < 64'd37_000_000 || fo > 64'd4_500_000_000) return;
    integ = (fi % 1_000_000 == 0) && (fo % 1_000_000 == 0);
    for (int s = 0; s <= 6; s++) begin
      vco = fo << s;
      if (vco < 64'd2_250_000_000 || vco > 64'd4_500_000_000) continue;
      for (int p = (integ ? 2 : 1); p <= 4; p++)
        for (int m = 64; m <= 1023; m++) begin
          longint unsigned lo, up;
          lo = longint'(m) * fi / longint'(p);
          up = longint'(m + 1) * fi / longint'(p);
          if (integ ? (lo == vco) : (lo <= vco && vco < up)) begin
            ok = 1; ep = p; em = m; es = s;
            if (!integ) begin
              fref = fi / longint'(p);
              ek = ((vco - longint'(m) * fref) * 65536 / fref) & 64'hFFFF;
            end
            return;
          end
        end
    end
  endfunction

  task automatic launch(input longint unsigned fi, input longint unsigned fo);
    @(negedge clk);
    ref_hz = FW'(fi); out_hz = FW'(fo); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", 64'(busy), 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic compare(input string tag, input longint unsigned fi, input longint unsigned fo);
    bit ok;
    longint unsigned ep, em, es, ek;
    model(fi, fo, ok, ep, em, es, ek);
    chk({tag, " fail flag"}, 64'(fail), ok ? 0 : 1);
    if (ok) begin
      chk("R3 shift", 64'(post_shift), es);
      chk("R7 pre-divider", 64'(pre_div), ep);
      chk("R7 multiplier", 64'(fb_mul), em);
      chk("R6 fraction", 64'(frac), ek);
    end
  endtask

  task automatic run_case(input string tag, input longint unsigned fi, input longint unsigned fo);
    launch(fi, fo);
    wait_done();
    compare(tag, fi, fo);
    @(negedge clk);
    chk("R9 done one cycle", 64'(done), 0);
    chk("R9 busy drops", 64'(busy), 0);
    compare("R9 hold", fi, fo);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", 64'(busy), 0);
    chk("R11 done in reset", 64'(done), 0);
    chk("R11 fail in reset", 64'(fail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy after reset", 64'(busy), 0);

    run_case("R1 zero ref",      0,                 64'd1_200_000_000);
    run_case("R1 zero out",      64'd24_000_000,    0);
    run_case("R1 equal",         64'd24_000_000,    64'd24_000_000);
    run_case("R2 below band",    64'd24_000_000,    64'd36_999_999);
    run_case("R2 above band",    64'd24_000_000,    64'd4_500_000_001);
    run_case("R2 band low edge", 64'd24_000_000,    64'd37_000_000);
    run_case("R2 band top edge", 64'd24_000_000,    64'd4_500_000_000);
    run_case("R4 integer",       64'd24_000_000,    64'd1_200_000_000);
    run_case("R4 integer P4",    64'd24_000_000,    64'd2_250_000_000);
    run_case("R4 other ref",     64'd25_000_000,    64'd3_000_000_000);
    run_case("R8 exhausted",     64'd24_000_000,    64'd2_251_000_000);
    run_case("R5 fractional",    64'd24_000_000,    64'd1_000_000_500);
    run_case("R5 odd ref",       64'd24_576_000,    64'd1_179_648_000);
    run_case("R5 low out",       64'd26_000_001,    64'd40_000_000);

    launch(64'd24_000_000, 64'd1_200_000_000);
    repeat (3) @(negedge clk);
    ref_hz = FW'(64'd25_000_000); out_hz = FW'(64'd3_000_000_000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    compare("R10 start mid-search", 64'd24_000_000, 64'd1_200_000_000);
    ref_hz = FW'(64'd24_000_000); out_hz = FW'(64'd4_500_000_000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 start on done ignored", 64'(busy), 0);
    repeat (2) @(negedge clk);
    chk("R10 still idle", 64'(busy), 0);
    compare("R10 result kept", 64'd24_000_000, 64'd1_200_000_000);
    run_case("R10 next request", 64'd24_000_000, 64'd4_500_000_000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule